// File: doc/BRIEF.md
# Glitch-free four-input clock multiplexer

This block drives one output clock from one of up to four input clocks. A 2-bit select input names the source, and it may change at any time while the clocks run. The number of inputs is fixed when the block is built, from one to four. A second build option picks how the switch happens. The first choice is a plain combinational pick. The second is a glitch-free handover: the old source is closed in its own clock domain before the new source is opened in its own domain.

In glitch-free form each source has a gate enable. A source's request passes through a two-flop synchroniser clocked by that source. The request may only start once no other source is requesting, synchronising or enabled. The enable flop itself changes on the falling edge of its source, so the gate only opens or closes while that clock is low. With a single input the block is a plain pass-through and ignores the select. A select value at or above the configured input count falls back to input 0. If the select is tied to zero, input 0 drives the output.

Top module: `clkMuxTop`

## Requirements
- R1: Select encoding is plain binary: 2'b00 picks clkIn[0], 2'b01 picks clkIn[1], 2'b10 picks clkIn[2] and 2'b11 picks clkIn[3]. Once a switch has settled, clkOut equals the selected input clock.
- R2: A select value greater than or equal to NUM_CLK is treated as 2'b00, so clkIn[0] drives clkOut.
- R3: With NUM_CLK = 1, clkOut equals clkIn[0] for every select value.
- R4: With GLITCH_FREE = 0, clkOut follows the selected input with no clock latency after a select change.
- R5: In glitch-free mode, clkOut never shows a high pulse shorter than the high phase of the fastest input, even while the select changes.
- R6: While rstN is low, all gate enables are clear and clkOut stays low in glitch-free mode.
- R7: After rstN is released, the source named by the select value is the first to be enabled.
- R8: At most one gate enable is set at any time. An enable only rises when every other enable is low, so clkOut never carries a high phase longer than the slowest input's high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | NUM_CLK | Candidate input clocks, bit k being source k |
| clkSel | input | 2 | Binary source select; may change at any time |
| rstN | input | 1 | Active-low asynchronous reset of the gate enables |
| clkOut | output | 1 | Selected, gated output clock |

## Verification
The bench builds four copies side by side. The main copy has four inputs with glitch-free switching. A three-input glitch-free copy makes select 2'b11 fall out of range. A four-input combinational copy shows the zero-latency path. A single-input copy has the select toggling under it. The four input clocks have unrelated half periods of 2.5, 3, 5 and 7 ns. Because of this, handovers land at many different phase offsets, and the pulse-width watch on the gated outputs sees both the fastest and the slowest source next to each other. Bursts of select changes faster than the synchroniser latency exercise the case where one source's request is cancelled mid-flight.

// File: rtl/clkMuxPkg.sv
`timescale 1ns/10ps
package clkMuxPkg;
  localparam int MAX_CLK = 4;

  // Control-to-datapath strobes: one gate enable per possible source.
  typedef struct packed {
    logic [MAX_CLK-1:0] gateEn;
  } gateStrobes_t;

  // Out-of-range selects fold back onto source 0.
  function automatic logic [1:0] effectiveSel(input logic [1:0] sel, input int numClk);
    return (int'(sel) < numClk) ? sel : 2'd0;
  endfunction
endpackage

// File: rtl/clkMuxCtrl.sv
`timescale 1ns/10ps
module clkMuxCtrl
  import clkMuxPkg::*;
#(
  parameter int NUM_CLK     = 4,
  parameter bit GLITCH_FREE = 1'b1
) (
  input  logic [NUM_CLK-1:0] clkIn,
  input  logic               rstN,
  input  logic [1:0]         selIdx,
  output gateStrobes_t       strobes
);
  localparam bit USE_GATING = GLITCH_FREE && (NUM_CLK > 1);

  generate
    if (USE_GATING) begin : gGate
      logic [NUM_CLK-1:0] syncA;
      logic [NUM_CLK-1:0] syncB;
      logic [NUM_CLK-1:0] enQ;
      logic [NUM_CLK-1:0] busy;

      // A source is busy from the first synchroniser stage until its gate closes.
      assign busy = syncA | syncB | enQ;

      for (genvar i = 0; i < NUM_CLK; i++) begin : gSrc
        logic othersIdle;
        logic want;
        logic stageA;
        logic stageB;
        logic gateQ;

        assign othersIdle = ((busy & ~(NUM_CLK'(1) << i)) == '0);
        assign want       = (selIdx == 2'(i)) && othersIdle;

        // Two-flop synchroniser in this source's own domain.
        always_ff @(posedge clkIn[i] or negedge rstN) begin
          if (!rstN) begin
            stageA <= 1'b0;
            stageB <= 1'b0;
          end else begin
            stageA <= want;
            stageB <= stageA;
          end
        end

        // Gate flop on the falling edge: the gate moves only while the clock is low.
        always_ff @(negedge clkIn[i] or negedge rstN) begin
          if (!rstN) gateQ <= 1'b0;
          else       gateQ <= stageB;
        end

        assign syncA[i] = stageA;
        assign syncB[i] = stageB;
        assign enQ[i]   = gateQ;
      end

      always_comb begin
        strobes = '0;
        strobes.gateEn[NUM_CLK-1:0] = enQ;
      end
    end else begin : gNoGate
      logic unusedCtrl;
      assign unusedCtrl = ^{clkIn, rstN, selIdx};
      assign strobes    = '0;
    end
  endgenerate
endmodule

// File: rtl/clkMuxPath.sv
`timescale 1ns/10ps
module clkMuxPath
  import clkMuxPkg::*;
#(
  parameter int NUM_CLK     = 4,
  parameter bit GLITCH_FREE = 1'b1
) (
  input  logic [NUM_CLK-1:0] clkIn,
  input  gateStrobes_t       strobes,
  input  logic [1:0]         selIdx,
  output logic               clkOut
);
  generate
    if (NUM_CLK == 1) begin : gSingle
      logic unusedPath;
      assign unusedPath = ^{strobes, selIdx};
      assign clkOut     = clkIn[0];
    end else if (GLITCH_FREE) begin : gGated
      logic unusedPath;
      assign unusedPath = ^{strobes, selIdx};
      assign clkOut     = |(clkIn & strobes.gateEn[NUM_CLK-1:0]);
    end else begin : gPlain
      logic unusedPath;
      assign unusedPath = ^strobes;
      always_comb begin
        clkOut = 1'b0;
        for (int k = 0; k < NUM_CLK; k++) begin
          if (selIdx == 2'(k)) clkOut = clkIn[k];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/clkMuxTop.sv
`timescale 1ns/10ps
module clkMuxTop
  import clkMuxPkg::*;
#(
  parameter int NUM_CLK     = 4,
  parameter bit GLITCH_FREE = 1'b1
) (
  input  logic [NUM_CLK-1:0] clkIn,
  input  logic [1:0]         clkSel,
  input  logic               rstN,
  output logic               clkOut
);
  logic [1:0]         selIdx;
  gateStrobes_t       strobes;
  logic [NUM_CLK-1:0] gateEn;

  assign selIdx = (NUM_CLK == 1) ? 2'd0 : effectiveSel(clkSel, NUM_CLK);
  assign gateEn = strobes.gateEn[NUM_CLK-1:0];

  clkMuxCtrl #(.NUM_CLK(NUM_CLK), .GLITCH_FREE(GLITCH_FREE)) ctrl (
    .clkIn(clkIn), .rstN(rstN), .selIdx(selIdx), .strobes(strobes)
  );

  clkMuxPath #(.NUM_CLK(NUM_CLK), .GLITCH_FREE(GLITCH_FREE)) path (
    .clkIn(clkIn), .strobes(strobes), .selIdx(selIdx), .clkOut(clkOut)
  );
endmodule

// File: rtl/clkMuxChecker.sv
`timescale 1ns/10ps
module clkMuxChecker
  import clkMuxPkg::*;
#(
  parameter int NUM_CLK     = 4,
  parameter bit GLITCH_FREE = 1'b1
) (
  input logic [NUM_CLK-1:0] clkIn,
  input logic [1:0]         clkSel,
  input logic               rstN,
  input logic               clkOut,
  input logic [NUM_CLK-1:0] gateEn
);
  generate
    if (NUM_CLK == 1) begin : gSingleChk
      // R3: output is high just before every falling edge of input 0
      a_r3_single_follows: assert property (@(negedge clkIn[0]) disable iff (!rstN)
        clkOut == 1'b1);
    end else if (GLITCH_FREE) begin : gGateChk
      for (genvar i = 0; i < NUM_CLK; i++) begin : gSrcChk
        // R8: never more than one gate open
        a_r8_enable_exclusive: assert property (@(posedge clkIn[i]) disable iff (!rstN)
          $onehot0(gateEn));
        // R8: a gate opens only with all others closed
        a_r8_handshake: assert property (@(posedge clkIn[i]) disable iff (!rstN)
          $rose(gateEn[i]) |-> ((gateEn & ~(NUM_CLK'(1) << i)) == '0));
        // R1: an open gate passes its clock's high phase to the output
        a_r1_pass_enabled: assert property (@(negedge clkIn[i]) disable iff (!rstN)
          gateEn[i] |-> clkOut);
        // R6: reset keeps every gate closed
        a_r6_reset_clears: assert property (@(posedge clkIn[i])
          !rstN |-> (gateEn == '0));
      end
    end else begin : gPlainChk
      for (genvar i = 0; i < NUM_CLK; i++) begin : gSrcChk
        // R4: the selected clock appears at the output with no latency
        a_r4_plain_follows: assert property (@(negedge clkIn[i]) disable iff (!rstN)
          (effectiveSel(clkSel, NUM_CLK) == 2'(i)) |-> clkOut);
      end
    end
  endgenerate
endmodule

bind clkMuxTop clkMuxChecker #(.NUM_CLK(NUM_CLK), .GLITCH_FREE(GLITCH_FREE)) chk (
  .clkIn(clkIn), .clkSel(clkSel), .rstN(rstN), .clkOut(clkOut), .gateEn(gateEn)
);

// File: tb/clkMuxTop_test.sv
`timescale 1ns/10ps
module clkMuxTop_test;
  logic clk0 = 1'b0;  // 200 MHz
  logic clk1 = 1'b0;
  logic clk2 = 1'b0;
  logic clk3 = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] clkSel = 2'd2;
  logic [3:0] clks;
  logic outMain, outOdd, outComb, outOne;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk0 = ~clk0;
  always #3   clk1 = ~clk1;
  always #5   clk2 = ~clk2;
  always #7   clk3 = ~clk3;
  assign clks = {clk3, clk2, clk1, clk0};

  clkMuxTop #(.NUM_CLK(4), .GLITCH_FREE(1'b1)) uut (
    .clkIn(clks), .clkSel(clkSel), .rstN(rstN), .clkOut(outMain));
  clkMuxTop #(.NUM_CLK(3), .GLITCH_FREE(1'b1)) uutOdd (
    .clkIn(clks[2:0]), .clkSel(clkSel), .rstN(rstN), .clkOut(outOdd));
  clkMuxTop #(.NUM_CLK(4), .GLITCH_FREE(1'b0)) uutComb (
    .clkIn(clks), .clkSel(clkSel), .rstN(rstN), .clkOut(outComb));
  clkMuxTop #(.NUM_CLK(1), .GLITCH_FREE(1'b1)) uutOne (
    .clkIn(clks[0:0]), .clkSel(clkSel), .rstN(rstN), .clkOut(outOne));

  typedef struct {
    int    expMain;
    int    expOdd;
    int    expComb;
    string tag;
  } item_t;
  item_t expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: set the select and push what each copy should settle to.
  task automatic drive(input logic [1:0] sel, input string tag);
    item_t it;
    clkSel     = sel;
    it.expMain = int'(sel);
    it.expOdd  = (int'(sel) < 3) ? int'(sel) : 0;  // R2 fold-back
    it.expComb = int'(sel);
    it.tag     = tag;
    expQ.push_back(it);
    #260;
  endtask

  // Pulse-width watch on the glitch-free outputs (R5, R8).
  realtime riseMain = 0.0, riseOdd = 0.0;
  int runts = 0, longs = 0, pulses = 0;
  always @(posedge outMain) riseMain = $realtime;
  always @(posedge outOdd)  riseOdd  = $realtime;
  always @(negedge outMain) if (rstN) begin
    pulses++;
    if ($realtime - riseMain < 2.4) runts++;
    if ($realtime - riseMain > 7.1) longs++;
  end
  always @(negedge outOdd) if (rstN) begin
    pulses++;
    if ($realtime - riseOdd < 2.4) runts++;
    if ($realtime - riseOdd > 7.1) longs++;
  end

  // Monitor: pop, let the handover settle, then compare many samples.
  initial begin
    forever begin
      wait (expQ.size() > 0);
      begin
        item_t it;
        int mMain, mOdd, mComb, mOne, combNow;
        it = expQ.pop_front();
        mMain = 0; mOdd = 0; mOne = 0;
        combNow = (outComb == clks[it.expComb]) ? 0 : 1;
        check(combNow == 0, "R4", {"plain copy immediately after ", it.tag},
              int'(outComb), int'(clks[it.expComb]));
        #200.5;
        mComb = 0;
        for (int k = 0; k < 40; k++) begin
          if (outMain != clks[it.expMain]) mMain++;
          if (outOdd  != clks[it.expOdd])  mOdd++;
          if (outComb != clks[it.expComb]) mComb++;
          if (outOne  != clks[0])          mOne++;
          #1;
        end
        check(mMain == 0, it.tag, "main copy mismatching samples", mMain, 0);
        check(mOdd  == 0, (it.expOdd != it.expMain) ? "R2" : it.tag,
              "three-input copy mismatching samples", mOdd, 0);
        check(mComb == 0, "R4", "plain copy mismatching samples", mComb, 0);
        check(mOne  == 0, "R3", "single-input copy mismatching samples", mOne, 0);
      end
    end
  end

  // Watchdog
  initial begin
    #100000;
    if (!done) begin
      check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowMain, lowOdd;
    lowMain = 0; lowOdd = 0;
    // R6: outputs stay low under reset while the clocks run
    #0.25;
    for (int k = 0; k < 60; k++) begin
      if (outMain) lowMain++;
      if (outOdd)  lowOdd++;
      #1;
    end
    check(lowMain == 0, "R6", "main copy high samples in reset", lowMain, 0);
    check(lowOdd  == 0, "R6", "three-input copy high samples in reset", lowOdd, 0);
    #40.5;
    rstN = 1'b1;
    // R7: select already at 2 when reset ends, source 2 comes up first
    expQ.push_back('{expMain: 2, expOdd: 2, expComb: 2, tag: "R7"});
    #260;
    drive(2'd0, "R1");
    drive(2'd1, "R1");
    drive(2'd3, "R1");   // R2 on the three-input copy
    drive(2'd2, "R1");
    drive(2'd0, "R1");
    drive(2'd3, "R2");
    // Burst of changes faster than the synchroniser latency (R5)
    clkSel = 2'd1; #4;
    clkSel = 2'd2; #4;
    clkSel = 2'd3; #4;
    clkSel = 2'd0; #4;
    clkSel = 2'd2; #6;
    drive(2'd1, "R5");
    clkSel = 2'd3; #9;
    clkSel = 2'd0; #9;
    drive(2'd2, "R8");
    check(runts == 0, "R5", "runt high pulses on gated outputs", runts, 0);
    check(longs == 0, "R8", "overlong high pulses on gated outputs", longs, 0);
    check(pulses > 100, "R1", "gated output pulses observed (at least 101)", pulses, 101);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule